// File: doc/BRIEF.md
# Tapped Segmented Shift Register, Dual Channel

This block holds two independent serial shift registers. Each channel is 64 stages long and is cut into four 16-stage segments, with a tap at the end of each segment. A channel has its own clock, write-enable and synchronous clear. Serial data enters the first stage on every rising edge. With write-enable low, the segments are chained end to start and the four taps show the last stage of each segment. With write-enable high, the taps are released: their output enables drop and the values presented on the tap inputs of the first three taps feed the first stage of the following segment. All four segments then shift in parallel, so a full 64-bit image loads in 16 clocks.

The bidirectional tap pins are split into a tap input, a tap output and an active-high output enable. A pad ring or a wired bus outside the block can rebuild a true three-state pin from these. In the default build a disabled tap output is forced low, so several such outputs can be ORed onto one shared line. The clear is meant for initialising a bench and has priority over shifting and loading.

Top module: `tsr_dual`

## Requirements
- R1: Each channel holds 64 bits in four segments of 16. Tap k (k = 0..3) reflects the bit at position 16·(k+1), counting the serial entry stage as position 1. The tap vector index is channel·4 + k.
- R2: On every rising edge of its clock, a channel captures `ch_din` into position 1, whatever the level of `ch_we`.
- R3: With `ch_we` low at an edge, position 16 moves into 17, position 32 into 33 and position 48 into 49, and the tap inputs have no effect.
- R4: Combinationally, each `tap_oe` of a channel equals the inverse of that channel's `ch_we`. While `ch_we` is high, every `tap_out` of that channel is 0. While `ch_we` is low, `tap_out` shows the tap bit.
- R5: With `ch_we` high at an edge, tap inputs k = 0, 1, 2 are captured into positions 17, 33 and 49 in place of the chained bits. Tap input 3 is never used.
- R6: Sixteen load-mode edges fill all 64 positions. The first bit presented to a segment then sits at its tap, and after j further normal-mode edges the tap shows the bit presented on load cycle j.
- R7: State changes only on a rising edge of the channel clock. With the clock held, the taps keep their values while the other inputs change.
- R8: The channels share no state. Clocking, loading or clearing one leaves the other's taps unchanged.
- R9: `ch_clr` high at an edge zeros all 64 positions of that channel, with priority over capture, shifting and loading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ch_clk | input | NUM_CH | Per-channel clock, rising edge active |
| ch_clr | input | NUM_CH | Per-channel synchronous clear, active high |
| ch_we | input | NUM_CH | Per-channel write enable: 1 = load mode, 0 = normal mode |
| ch_din | input | NUM_CH | Per-channel serial data into position 1 |
| tap_in | input | NUM_CH·NUM_SEG | Tap pin input values, index channel·NUM_SEG + k |
| tap_out | output | NUM_CH·NUM_SEG | Tap pin output values, same indexing |
| tap_oe | output | NUM_CH·NUM_SEG | Tap pin output enables, active high |

## Verification
The bench loads known 16-bit patterns through all four entry points at once. It then shifts them out in normal mode, which catches a reversed load order or a segment fed from the wrong tap: each of those puts the wrong pattern bit on a tap. It drives the top tap input and the tap inputs in normal mode with garbage, so a design that let either through would corrupt the following segment. It checks that clear wins over a simultaneous load, that taps hold while the clock is stopped, and that clocking one channel leaves the other frozen. A shared register or a crossed clock would show up as the idle channel moving.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

   typedef enum logic {
      MODE_SHIFT = 1'b0,
      MODE_LOAD  = 1'b1
   } tsr_mode_e;

   function automatic tsr_mode_e mode_of(input logic we);
      return we ? MODE_LOAD : MODE_SHIFT;
   endfunction

endpackage

// File: rtl/tsr_segment.sv
module tsr_segment #(
   parameter int SEG_LEN = 16
) (
   input  logic clk,
   input  logic clr,
   input  logic entry,
   output logic last
);
   localparam int TOP = SEG_LEN - 1;

   logic [TOP:0] stages;

   always_ff @(posedge clk) begin
      if (clr) begin
         stages <= '0;
      end else begin
         stages <= {stages[TOP-1:0], entry};
      end
   end

   assign last = stages[TOP];

endmodule

// File: rtl/tsr_tap_drive.sv
module tsr_tap_drive #(
   parameter bit GATE_IDLE = 1'b1
) (
   input  logic we,
   input  logic stored,
   output logic pin_out,
   output logic pin_oe
);
   assign pin_oe = ~we;

   generate
      if (GATE_IDLE) begin : g_gated
         assign pin_out = stored & ~we;
      end else begin : g_open
         assign pin_out = stored;
      end
   endgenerate

endmodule

// File: rtl/tsr_channel.sv
module tsr_channel
   import tsr_pkg::*;
#(
   parameter int NUM_SEG   = 4,
   parameter int SEG_LEN   = 16,
   parameter bit GATE_IDLE = 1'b1
) (
   input  logic               clk,
   input  logic               clr,
   input  logic               we,
   input  logic               din,
   input  logic [NUM_SEG-1:0] tap_in,
   output logic [NUM_SEG-1:0] tap_out,
   output logic [NUM_SEG-1:0] tap_oe
);
   tsr_mode_e mode;
   logic [NUM_SEG-1:0] seg_last;
   logic [NUM_SEG-1:0] seg_entry;
   logic unused_final_tap_in;

   assign mode = mode_of(we);
   assign unused_final_tap_in = tap_in[NUM_SEG-1];

   generate
      for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
         if (k == 0) begin : g_head
            assign seg_entry[k] = din;
         end else begin : g_link
            always_comb begin
               unique case (mode)
                  MODE_LOAD:  seg_entry[k] = tap_in[k-1];
                  default:    seg_entry[k] = seg_last[k-1];
               endcase
            end
         end

         tsr_segment #(
            .SEG_LEN(SEG_LEN)
         ) u_seg (
            .clk  (clk),
            .clr  (clr),
            .entry(seg_entry[k]),
            .last (seg_last[k])
         );

         tsr_tap_drive #(
            .GATE_IDLE(GATE_IDLE)
         ) u_tap (
            .we     (we),
            .stored (seg_last[k]),
            .pin_out(tap_out[k]),
            .pin_oe (tap_oe[k])
         );
      end
   endgenerate

endmodule

// File: rtl/tsr_dual.sv
module tsr_dual #(
   parameter int NUM_CH         = 2,
   parameter int NUM_SEG        = 4,
   parameter int SEG_LEN        = 16,
   parameter bit GATE_IDLE_TAPS = 1'b1
) (
   input  logic [NUM_CH-1:0]         ch_clk,
   input  logic [NUM_CH-1:0]         ch_clr,
   input  logic [NUM_CH-1:0]         ch_we,
   input  logic [NUM_CH-1:0]         ch_din,
   input  logic [NUM_CH*NUM_SEG-1:0] tap_in,
   output logic [NUM_CH*NUM_SEG-1:0] tap_out,
   output logic [NUM_CH*NUM_SEG-1:0] tap_oe
);
   localparam int CH_BITS = NUM_SEG * SEG_LEN;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("tsr_dual: NUM_CH must be at least 1");
      end
      if (NUM_SEG < 2) begin : g_bad_seg
         $error("tsr_dual: NUM_SEG must be at least 2");
      end
      if (SEG_LEN < 2) begin : g_bad_len
         $error("tsr_dual: SEG_LEN must be at least 2");
      end
      if (CH_BITS > 4096) begin : g_bad_size
         $error("tsr_dual: channel depth too large");
      end

      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         tsr_channel #(
            .NUM_SEG  (NUM_SEG),
            .SEG_LEN  (SEG_LEN),
            .GATE_IDLE(GATE_IDLE_TAPS)
         ) u_chan (
            .clk    (ch_clk[c]),
            .clr    (ch_clr[c]),
            .we     (ch_we[c]),
            .din    (ch_din[c]),
            .tap_in (tap_in [c*NUM_SEG +: NUM_SEG]),
            .tap_out(tap_out[c*NUM_SEG +: NUM_SEG]),
            .tap_oe (tap_oe [c*NUM_SEG +: NUM_SEG])
         );
      end
   endgenerate

endmodule

// File: rtl/tsr_dual_checker.sv
module tsr_dual_checker #(
   parameter int NUM_CH         = 2,
   parameter int NUM_SEG        = 4,
   parameter bit GATE_IDLE_TAPS = 1'b1
) (
   input logic [NUM_CH-1:0]         ch_clk,
   input logic [NUM_CH-1:0]         ch_clr,
   input logic [NUM_CH-1:0]         ch_we,
   input logic [NUM_CH*NUM_SEG-1:0] tap_out,
   input logic [NUM_CH*NUM_SEG-1:0] tap_oe
);
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
         AST_OE_OFF_ON_LOAD: assert property (@(posedge ch_clk[c]) disable iff (ch_clr[c])
            $rose(ch_we[c]) |-> (tap_oe[c*NUM_SEG +: NUM_SEG] == '0)); // R4

         AST_OE_ON_ON_SHIFT: assert property (@(posedge ch_clk[c]) disable iff (ch_clr[c])
            $fell(ch_we[c]) |-> (tap_oe[c*NUM_SEG +: NUM_SEG] == '1)); // R4

         AST_CLEAR_EMPTIES: assert property (@(posedge ch_clk[c]) disable iff (ch_clr[c])
            ($past(ch_clr[c]) && !ch_we[c]) |-> (tap_out[c*NUM_SEG +: NUM_SEG] == '0)); // R9

         if (GATE_IDLE_TAPS) begin : g_quiet
            AST_TAPS_QUIET_LOADING: assert property (@(posedge ch_clk[c]) disable iff (ch_clr[c])
               ch_we[c] |-> (tap_out[c*NUM_SEG +: NUM_SEG] == '0)); // R4
         end
      end
   endgenerate

endmodule

bind tsr_dual tsr_dual_checker #(
   .NUM_CH        (NUM_CH),
   .NUM_SEG       (NUM_SEG),
   .GATE_IDLE_TAPS(GATE_IDLE_TAPS)
) u_tsr_dual_checker (
   .ch_clk (ch_clk),
   .ch_clr (ch_clr),
   .ch_we  (ch_we),
   .tap_out(tap_out),
   .tap_oe (tap_oe)
);

// File: tb/tsr_dual_test.sv
module tsr_dual_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 2;
   localparam int NSEG = 4;
   localparam int SLEN = 16;
   localparam int TOT  = NSEG * SLEN;

   logic [NCH-1:0]      ch_clk = '0;
   logic [NCH-1:0]      ch_clr = '0;
   logic [NCH-1:0]      ch_we  = '0;
   logic [NCH-1:0]      ch_din = '0;
   logic [NCH*NSEG-1:0] tap_in = '0;
   logic [NCH*NSEG-1:0] tap_out;
   logic [NCH*NSEG-1:0] tap_oe;

   logic [TOT-1:0] model [NCH];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   tsr_dual #(
      .NUM_CH(NCH), .NUM_SEG(NSEG), .SEG_LEN(SLEN), .GATE_IDLE_TAPS(1'b1)
   ) uut (
      .ch_clk(ch_clk), .ch_clr(ch_clr), .ch_we(ch_we), .ch_din(ch_din),
      .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
   );

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         report();
         $finish;
      end
   end

   task automatic cmp(input string req, input int idx, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s tap %0d: got %b expected %b", req, idx, got, exp);
      end
   endtask

   // Model update from the requirements: position p+1 is model index p.
   task automatic model_step(input int c, input bit clr, input bit we, input bit din,
                             input logic [NSEG-1:0] tin);
      logic [TOT-1:0] nxt;
      if (clr) begin
         model[c] = '0;
         return;
      end
      nxt[0] = din;
      for (int i = 1; i < TOT; i++) begin
         if (we && (i % SLEN == 0)) nxt[i] = tin[i/SLEN - 1];
         else                       nxt[i] = model[c][i-1];
      end
      model[c] = nxt;
   endtask

   task automatic edge_ch(input int c, input bit clr, input bit we, input bit din,
                          input logic [NSEG-1:0] tin);
      ch_clr[c] = clr;
      ch_we[c]  = we;
      ch_din[c] = din;
      tap_in[c*NSEG +: NSEG] = tin;
      #1;
      ch_clk[c] = 1'b1;
      #(CLK_PERIOD/2);
      ch_clk[c] = 1'b0;
      #(CLK_PERIOD/2 - 1);
      model_step(c, clr, we, din, tin);
      ch_clr[c] = 1'b0;
   endtask

   task automatic check_taps(input int c, input string req);
      for (int k = 0; k < NSEG; k++) begin
         cmp(req, c*NSEG + k, tap_out[c*NSEG + k],
             ch_we[c] ? 1'b0 : model[c][SLEN*(k+1) - 1]);
         cmp({req, "/R4 oe"}, c*NSEG + k, tap_oe[c*NSEG + k], ~ch_we[c]);
      end
   endtask

   function automatic logic [15:0] pat(input int c, input int r, input int k);
      return 16'((c*7 + r*13 + k*29 + 1) * 40503) ^ 16'(r * 4369);
   endfunction

   logic [15:0] p [NSEG];
   logic [NSEG*NCH-1:0] frozen;

   initial begin
      for (int c = 0; c < NCH; c++) model[c] = '0;

      // R9: clear both channels, taps read zero
      for (int c = 0; c < NCH; c++) begin
         edge_ch(c, 1'b1, 1'b0, 1'b1, '1);
         check_taps(c, "R9 reset");
      end

      // R2/R1: fill channel 0 with ones serially, then R9 clear wins over a load
      for (int i = 0; i < TOT; i++) edge_ch(0, 1'b0, 1'b0, 1'b1, '0);
      check_taps(0, "R1 fill");
      edge_ch(0, 1'b1, 1'b1, 1'b1, '1);
      ch_we[0] = 1'b0;
      #1;
      check_taps(0, "R9 clear priority");

      // R5/R6: parallel loads then shift out, several patterns per channel
      for (int c = 0; c < NCH; c++) begin
         for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < NSEG; k++) p[k] = pat(c, r, k);
            for (int i = 0; i < SLEN; i++) begin
               // tap input 3 toggles as garbage: R5 says it is unused
               edge_ch(c, 1'b0, 1'b1, p[0][i], {1'(i), p[3][i], p[2][i], p[1][i]});
               check_taps(c, "R4 load");
            end
            ch_we[c] = 1'b0;
            #1;
            for (int j = 0; j < SLEN; j++) begin
               for (int k = 0; k < NSEG; k++) begin
                  cmp("R6 load order", c*NSEG + k, tap_out[c*NSEG + k],
                      (k == NSEG-1 && j == SLEN) ? 1'b0 : p[k][j]);
               end
               // garbage on tap inputs in normal mode: R3 says ignored
               edge_ch(c, 1'b0, 1'b0, 1'b0, 4'(j * 5 + r));
               check_taps(c, "R3 chain");
            end
         end
      end

      // R2/R3/R5: mixed mode serial run against the model
      for (int c = 0; c < NCH; c++) begin
         for (int i = 0; i < 96; i++) begin
            logic [15:0] v;
            v = 16'((i * 37 + c * 11) * 2654435);
            edge_ch(c, 1'b0, (v[3:0] == 4'd7) || (v[3:0] == 4'd12), v[5], v[11:8]);
            check_taps(c, "R2 mixed");
         end
         ch_we[c] = 1'b0;
         #1;
         check_taps(c, "R5 mixed");
      end

      // R7: clock held, other inputs wiggle, taps hold
      frozen = tap_out;
      for (int i = 0; i < 8; i++) begin
         ch_din = 2'(i);
         tap_in = 8'(i * 29);
         ch_clr = '0;
         #(CLK_PERIOD);
         for (int t = 0; t < NCH*NSEG; t++) cmp("R7 hold", t, tap_out[t], frozen[t]);
      end

      // R8: clock only channel 1, channel 0 must stay frozen
      for (int i = 0; i < 20; i++) begin
         edge_ch(1, 1'b0, 1'b0, 1'(i % 3 == 0), '1);
         check_taps(1, "R8 active");
         for (int k = 0; k < NSEG; k++) cmp("R8 idle", k, tap_out[k], frozen[k]);
      end
      edge_ch(1, 1'b1, 1'b0, 1'b1, '0);
      check_taps(1, "R9 ch1 clear");
      for (int k = 0; k < NSEG; k++) cmp("R8 idle after clear", k, tap_out[k], frozen[k]);

      done = 1;
      report();
      $finish;
   end

endmodule